// File: doc/BRIEF.md
# Timer External Match Output Controller

This block produces the external match output levels of a general-purpose timer. There are four channels. Each one receives an already-decoded, single-cycle match pulse, which means the timer count has reached that channel's compare value. Each channel also has a 2-bit action code that decides what the pulse does to its output level: keep it, drive it low, drive it high, or invert it. The output levels go straight to the pins in positive logic. Channels 0 and 1 also send a one-cycle request to a DMA engine whenever their match pulse fires.

Software sees the block as one 16-bit control/status word. The low four bits are the live output levels. Above them sit the four action codes, one 2-bit field per channel. A write loads the levels and the codes together. A read returns them, with the unused upper bits reading as zero.

Each channel is a two-state machine with the states `ST_LOW` and `ST_HIGH`. It has these transitions:
- `T_HOLD` (a match with code 00) stays in the current state.
- `T_CLEAR` (code 01) goes to `ST_LOW`.
- `T_SET` (code 10) goes to `ST_HIGH`.
- `T_TOGGLE` (code 11) goes to the other state.
- `T_LOAD` (a register write with no match on that channel) goes to the state given by the written bit.

With neither a match nor a write, the channel stays where it is.

Top module: `tmr_match_out`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `rd_data` is 0x0000, `mat_pin` is 0 and `dma_req` is 0.
- R2: `rd_data` is laid out as follows. Bits 3:0 are the output levels of channels 0 to 3. The action codes sit at bits 5:4 for channel 0, 7:6 for channel 1, 9:8 for channel 2 and 11:10 for channel 3. Bits 15:12 always read 0, even after a write that sets them to 1.
- R3: A write (`wr_en`=1) with no match pulse loads `wr_data[11:0]` into the word. The new value is visible on the cycle after the write.
- R4: A match pulse on a channel whose code is 00 leaves its level unchanged.
- R5: A match pulse on a channel whose code is 01 makes its level 0 on the next cycle.
- R6: A match pulse on a channel whose code is 10 makes its level 1 on the next cycle.
- R7: A match pulse on a channel whose code is 11 inverts its level on the next cycle.
- R8: A write and a match pulse can hit the same channel in the same cycle. The level then follows the match action, and the action used is the code held before the write. The written code is still stored.
- R9: Match pulses on several channels in the same cycle are each applied independently.
- R10: `dma_req[c]` for channels 0 and 1 is high for exactly one cycle, on the cycle after a match pulse on channel c, whatever that channel's code is.
- R11: `mat_pin[c]` equals the stored level of channel c (1 is high).
- R12: With no write and no match pulse, the levels and codes stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| match_evt | input | 4 | Single-cycle match pulses, one per channel |
| mat_pin | output | 4 | External match output pins |
| dma_req | output | 2 | One-cycle DMA requests for channels 0 and 1 |

## Verification
Every result of the block is due exactly one cycle after the rising edge that captures its stimulus. This covers the levels, the codes, the pins and the DMA pulses alike, because each comes from one register stage. The bench changes inputs on the falling edge. A behavioural model updates on the following rising edge, and the outputs are compared against it on the next falling edge, so each comparison falls in the cycle where the result is due. The same-cycle write and match case uses the code from the model's state before the write.

// File: rtl/tmr_match_pkg.sv
package tmr_match_pkg;

    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        ACT_HOLD   = 2'b00,
        ACT_CLEAR  = 2'b01,
        ACT_SET    = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } lvl_state_e;

endpackage

// File: rtl/tmr_match_chan.sv
module tmr_match_chan
    import tmr_match_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic              wr_en,
    input  logic              wr_level,
    input  logic [CODE_W-1:0] wr_code,
    output logic              level,
    output logic [CODE_W-1:0] code
);

    lvl_state_e state_q, state_d;
    act_e       code_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
            code_q  <= ACT_HOLD;
        end else begin
            state_q <= state_d;
            if (wr_en) code_q <= act_e'(wr_code);
        end
    end

    // Transition logic: a match takes priority over a write
    always_comb begin
        state_d = state_q;
        if (match) begin
            unique case (code_q)
                ACT_HOLD:   state_d = state_q;                       // T_HOLD
                ACT_CLEAR:  state_d = ST_LOW;                        // T_CLEAR
                ACT_SET:    state_d = ST_HIGH;                       // T_SET
                ACT_TOGGLE: state_d = (state_q == ST_HIGH) ? ST_LOW
                                                            : ST_HIGH; // T_TOGGLE
                default:    state_d = state_q;
            endcase
        end else if (wr_en) begin
            state_d = wr_level ? ST_HIGH : ST_LOW;                   // T_LOAD
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_HIGH: level = 1'b1;
            default: level = 1'b0;
        endcase
        code = code_q;
    end

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (match && code == ACT_HOLD) |=> $stable(level));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (match && code == ACT_CLEAR) |=> !level);
    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (match && code == ACT_SET) |=> level);
    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && code == ACT_TOGGLE) |=> (level != $past(level)));
    p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !wr_en) |=> ($stable(level) && $stable(code)));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && wr_en) |=> (level == $past(wr_level) && code == $past(wr_code)));

endmodule

// File: rtl/tmr_match_dma.sv
module tmr_match_dma #(
    parameter int DMA_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DMA_CH-1:0] evt,
    output logic [DMA_CH-1:0] req
);

    logic [DMA_CH-1:0] req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= evt;
    end

    assign req = req_q;

    generate
        for (genvar c = 0; c < DMA_CH; c++) begin : g_chk
            p_dma_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
                evt[c] |=> req[c]);
            p_dma_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !evt[c] |=> !req[c]);
        end
    endgenerate

endmodule

// File: rtl/tmr_match_out.sv
module tmr_match_out
    import tmr_match_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DMA_CH = 2,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] match_evt,
    output logic [NUM_CH-1:0] mat_pin,
    output logic [DMA_CH-1:0] dma_req
);

    localparam int CODE_LSB = NUM_CH;
    localparam int USED_W   = NUM_CH + NUM_CH * CODE_W;

    logic [NUM_CH-1:0]        levels;
    logic [NUM_CH*CODE_W-1:0] codes;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            tmr_match_chan u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .match    (match_evt[c]),
                .wr_en    (wr_en),
                .wr_level (wr_data[c]),
                .wr_code  (wr_data[CODE_LSB + c*CODE_W +: CODE_W]),
                .level    (levels[c]),
                .code     (codes[c*CODE_W +: CODE_W])
            );
        end
    endgenerate

    tmr_match_dma #(.DMA_CH(DMA_CH)) u_dma (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (match_evt[DMA_CH-1:0]),
        .req   (dma_req)
    );

    always_comb begin
        rd_data                  = '0;
        rd_data[NUM_CH-1:0]      = levels;
        rd_data[USED_W-1:NUM_CH] = codes;
    end

    assign mat_pin = levels;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:USED_W] == '0);

endmodule

// File: tb/tmr_match_out_test.sv
module tmr_match_out_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [3:0]  match_evt = '0;
    logic [3:0]  mat_pin;
    logic [1:0]  dma_req;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    int m_lvl[4];
    int m_code[4];
    int m_dma[2];

    tmr_match_out uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .match_evt(match_evt), .mat_pin(mat_pin),
        .dma_req(dma_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] model_word();
        logic [15:0] w = '0;
        for (int c = 0; c < 4; c++) begin
            w[c] = m_lvl[c][0];
            w[4 + 2*c +: 2] = m_code[c][1:0];
        end
        return w;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive on falling edge, update model at rising edge, compare on next falling edge
    task automatic step(bit we, logic [15:0] wd, logic [3:0] ev, string tag);
        int nl[4];
        wr_en = we; wr_data = wd; match_evt = ev;
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            if (ev[c]) begin
                case (m_code[c])
                    0: nl[c] = m_lvl[c];
                    1: nl[c] = 0;
                    2: nl[c] = 1;
                    default: nl[c] = 1 - m_lvl[c];
                endcase
            end else if (we) nl[c] = wd[c];
            else nl[c] = m_lvl[c];
        end
        for (int c = 0; c < 4; c++) begin
            m_lvl[c] = nl[c];
            if (we) m_code[c] = wd[4 + 2*c +: 2];
        end
        for (int c = 0; c < 2; c++) m_dma[c] = ev[c];
        @(negedge clk);
        wr_en = 1'b0; match_evt = '0;
        check({tag, " word"}, rd_data, model_word());
        check("R11 pins", {12'b0, mat_pin}, {12'b0, model_word()[3:0]});
        check("R10 dma", {14'b0, dma_req}, {14'b0, m_dma[1][0], m_dma[0][0]});
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_lvl[c] = 0; m_code[c] = 0; end
        m_dma[0] = 0; m_dma[1] = 0;
        repeat (3) @(negedge clk);
        check("R1 reset word", rd_data, 16'h0000);
        check("R1 reset dma", {14'b0, dma_req}, 16'h0000);
        rst_n = 1'b1;
        step(0, 16'h0000, 4'b0000, "R1 after release");

        // codes: ch0 set, ch1 clear, ch2 toggle, ch3 hold; levels 0101; reserved ones
        step(1, 16'hF365, 4'b0000, "R3 R2 write");
        check("R2 reserved zero", {12'b0, rd_data[15:12]}, 16'h0000);
        step(0, 16'h0000, 4'b0000, "R12 idle");
        step(0, 16'h0000, 4'b0001, "R6 set ch0");
        step(0, 16'h0000, 4'b0010, "R5 clear ch1");
        step(0, 16'h0000, 4'b0100, "R7 toggle ch2 a");
        step(0, 16'h0000, 4'b0100, "R7 toggle ch2 b");
        step(0, 16'h0000, 4'b1000, "R4 hold ch3");
        step(0, 16'h0000, 4'b1111, "R9 all channels");
        step(1, 16'h0FFA, 4'b0000, "R3 write all toggle");
        step(0, 16'h0000, 4'b0011, "R9 R7 ch0 ch1");
        step(0, 16'h0000, 4'b0000, "R10 dma falls");
        // write and match same cycle: old code toggle applies, new code stored
        step(1, 16'h0550, 4'b0101, "R8 conflict");
        step(0, 16'h0000, 4'b1111, "R8 new codes clear");
        step(1, 16'h0AAF, 4'b0000, "R3 write set codes");
        step(0, 16'h0000, 4'b0000, "R12 idle b");
        step(1, 16'h0003, 4'b1010, "R8 set wins over load");
        step(0, 16'h0000, 4'b0010, "R4 hold after write");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule